// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire bus. A bit-level time-slot engine below it turns bus activity into three kinds of events: a bus reset (with a qualifier that says whether the low time was long), assembled bytes, and a strobe that reports a won identity search. The layer reads the first byte after each bus reset as a ROM command. It may then compare a 64-bit device identity. It decides whether the slave moves on to the memory/control stage, signalled by a one-cycle pulse, or stays silent until the next bus reset.

Two flags persist across bus resets. The resume flag lets a master that has already selected this slave select it again without sending the identity. The speed flag tells the slot engine to use fast timing. Only the two fast-speed commands set the speed flag, and only a long bus reset clears it. A failed fast-speed match puts the flag back to the value it had before the command.

Top module: `sw_rom_layer`

## Requirements
- R1: After `rst`, `od_mode` and `fn_enter` are 0 and the resume flag is clear. Bytes are ignored until the first `bus_reset`.
- R2: A `bus_reset` pulse returns the layer to waiting for a command byte, whatever it was doing. It takes priority over a byte or strobe in the same cycle. With `reset_long`=1 it clears `od_mode`; with `reset_long`=0 `od_mode` keeps its value.
- R3: Command 55h is followed by 8 identity bytes, least significant byte (`DEV_ID[7:0]`) first. If all 8 match, `fn_enter` pulses on the edge that accepts the 8th byte and the resume flag is set. Idle cycles between bytes are allowed.
- R4: If any identity byte after 55h differs, there is no `fn_enter` and the resume flag is cleared. All later bytes are ignored until the next `bus_reset`.
- R5: Command CCh pulses `fn_enter` on the edge that accepts it and clears the resume flag.
- R6: Command 3Ch sets `od_mode` to 1, pulses `fn_enter` and clears the resume flag, all on the edge that accepts it.
- R7: Command 69h sets `od_mode` to 1 on the edge that accepts it. An exact 8-byte identity match then pulses `fn_enter`, sets the resume flag and leaves `od_mode` at 1.
- R8: When the identity after 69h does not match, `od_mode` returns to its value from before the 69h byte (so it stays 1 if it was already 1) and the resume flag is cleared.
- R9: Command A5h pulses `fn_enter` on the edge that accepts it if the resume flag is set. If the flag is clear, there is no pulse and the layer ignores bytes until the next `bus_reset`.
- R10: Command F0h clears the resume flag and waits for `search_ok`. A `search_ok` then pulses `fn_enter` and sets the resume flag. `search_ok` has no effect in any other phase.
- R11: Any other command byte sends the layer to silence with no `fn_enter`. Bytes that arrive after `fn_enter` belong to the memory stage and change nothing here.
- R12: `fn_enter` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| reset_long | input | 1 | Qualifies `bus_reset`: low time was long enough to drop fast speed |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte |
| search_ok | input | 1 | One-cycle strobe: the identity search was won by this slave |
| od_mode | output | 1 | Fast-speed flag for the slot engine |
| fn_enter | output | 1 | One-cycle pulse: proceed to the memory/control stage |

## Verification
Every result is registered. `fn_enter` and `od_mode` change on the rising edge that samples the deciding byte, strobe or bus reset, and are visible in the cycle after it. The resume flag is observed only through the outcome of a later A5h. The bench drives each input at the falling edge and advances its reference model by one edge per cycle. It compares both outputs at the next falling edge, so every check falls exactly one cycle after its stimulus. Sequences cover identity mismatches in the first and last byte, gaps between identity bytes, and a fast-speed match that fails both from standard speed and from fast speed.

// File: rtl/romlayer_pkg.sv
package romlayer_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_MATCH    = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_SKIP     = 8'hCC;
    localparam logic [BYTE_W-1:0] CMD_RESUME   = 8'hA5;
    localparam logic [BYTE_W-1:0] CMD_OD_SKIP  = 8'h3C;
    localparam logic [BYTE_W-1:0] CMD_OD_MATCH = 8'h69;
    localparam logic [BYTE_W-1:0] CMD_SEARCH   = 8'hF0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_IDENT,
        PH_SEARCH,
        PH_FUNC
    } rom_phase_e;

    typedef enum logic [2:0] {
        OP_MATCH,
        OP_SKIP,
        OP_RESUME,
        OP_OD_SKIP,
        OP_OD_MATCH,
        OP_SEARCH,
        OP_BAD
    } rom_op_e;

    // Strobes from the sequencer to the flag and comparator units
    typedef struct packed {
        logic rs_set;
        logic rs_clr;
        logic od_set;
        logic od_restore;
        logic id_clear;
        logic id_step;
    } rom_ctl_t;

    function automatic rom_op_e decode_op(input logic [BYTE_W-1:0] b);
        case (b)
            CMD_MATCH:    return OP_MATCH;
            CMD_SKIP:     return OP_SKIP;
            CMD_RESUME:   return OP_RESUME;
            CMD_OD_SKIP:  return OP_OD_SKIP;
            CMD_OD_MATCH: return OP_OD_MATCH;
            CMD_SEARCH:   return OP_SEARCH;
            default:      return OP_BAD;
        endcase
    endfunction

endpackage

// File: rtl/rom_id_cmp.sv
module rom_id_cmp
    import romlayer_pkg::*;
#(
    parameter int          ID_W   = 64,
    parameter logic [ID_W-1:0] DEV_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [BYTE_W-1:0] data,
    output logic              id_last,
    output logic              id_match
);

    localparam int ID_BYTES = ID_W / BYTE_W;
    localparam int CNT_W    = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    logic [BYTE_W-1:0] id_bytes [ID_BYTES];
    logic [CNT_W-1:0]  cnt_q;
    logic              miss_q;
    logic              byte_eq;

    // Split the identity into bytes, least significant first
    for (genvar g = 0; g < ID_BYTES; g++) begin : g_idb
        assign id_bytes[g] = DEV_ID[g*BYTE_W +: BYTE_W];
    end

    assign byte_eq  = (data == id_bytes[cnt_q]);
    assign id_last  = (cnt_q == CNT_W'(ID_BYTES - 1));
    assign id_match = !miss_q && byte_eq;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            miss_q <= 1'b0;
        end else if (step) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            miss_q <= miss_q | !byte_eq;
        end
    end

endmodule

// File: rtl/rom_flag_regs.sv
module rom_flag_regs
    import romlayer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_reset,
    input  logic     reset_long,
    input  rom_ctl_t ctl,
    output logic     resume_q,
    output logic     od_q
);

    logic od_saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resume_q   <= 1'b0;
            od_q       <= 1'b0;
            od_saved_q <= 1'b0;
        end else if (bus_reset) begin
            if (reset_long) begin
                od_q <= 1'b0;
            end
        end else begin
            if (ctl.od_set) begin
                od_saved_q <= od_q;
                od_q       <= 1'b1;
            end else if (ctl.od_restore) begin
                od_q <= od_saved_q;
            end
            if (ctl.rs_set) begin
                resume_q <= 1'b1;
            end else if (ctl.rs_clr) begin
                resume_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rom_ctrl_fsm.sv
module rom_ctrl_fsm
    import romlayer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              search_ok,
    input  logic              resume_q,
    input  logic              id_last,
    input  logic              id_match,
    output rom_ctl_t          ctl,
    output rom_phase_e        phase_q,
    output logic              fn_enter_q
);

    rom_phase_e phase_n;
    logic       enter_n;
    logic       od_cmd_q;
    logic       od_cmd_n;
    rom_op_e    op;

    assign op = decode_op(byte_data);

    always_comb begin
        ctl      = '0;
        phase_n  = phase_q;
        enter_n  = 1'b0;
        od_cmd_n = od_cmd_q;
        if (bus_reset) begin
            phase_n      = PH_CMD;
            ctl.id_clear = 1'b1;
        end else begin
            case (phase_q)
                PH_CMD: begin
                    if (byte_vld) begin
                        case (op)
                            OP_MATCH: begin
                                ctl.id_clear = 1'b1;
                                od_cmd_n     = 1'b0;
                                phase_n      = PH_IDENT;
                            end
                            OP_OD_MATCH: begin
                                ctl.id_clear = 1'b1;
                                ctl.od_set   = 1'b1;
                                od_cmd_n     = 1'b1;
                                phase_n      = PH_IDENT;
                            end
                            OP_SKIP: begin
                                ctl.rs_clr = 1'b1;
                                enter_n    = 1'b1;
                                phase_n    = PH_FUNC;
                            end
                            OP_OD_SKIP: begin
                                ctl.rs_clr = 1'b1;
                                ctl.od_set = 1'b1;
                                enter_n    = 1'b1;
                                phase_n    = PH_FUNC;
                            end
                            OP_RESUME: begin
                                if (resume_q) begin
                                    enter_n = 1'b1;
                                    phase_n = PH_FUNC;
                                end else begin
                                    phase_n = PH_IDLE;
                                end
                            end
                            OP_SEARCH: begin
                                ctl.rs_clr = 1'b1;
                                phase_n    = PH_SEARCH;
                            end
                            default: phase_n = PH_IDLE;
                        endcase
                    end
                end
                PH_IDENT: begin
                    if (byte_vld) begin
                        ctl.id_step = 1'b1;
                        if (id_last) begin
                            if (id_match) begin
                                ctl.rs_set = 1'b1;
                                enter_n    = 1'b1;
                                phase_n    = PH_FUNC;
                            end else begin
                                ctl.rs_clr     = 1'b1;
                                ctl.od_restore = od_cmd_q;
                                phase_n        = PH_IDLE;
                            end
                        end
                    end
                end
                PH_SEARCH: begin
                    if (search_ok) begin
                        ctl.rs_set = 1'b1;
                        enter_n    = 1'b1;
                        phase_n    = PH_FUNC;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            fn_enter_q <= 1'b0;
            od_cmd_q   <= 1'b0;
        end else begin
            phase_q    <= phase_n;
            fn_enter_q <= enter_n;
            od_cmd_q   <= od_cmd_n;
        end
    end

endmodule

// File: rtl/sw_rom_layer.sv
module sw_rom_layer
    import romlayer_pkg::*;
#(
    parameter int              ID_W   = 64,
    parameter logic [ID_W-1:0] DEV_ID = 64'h3D5A_9C17_E402_B86F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              reset_long,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              search_ok,
    output logic              od_mode,
    output logic              fn_enter
);

    rom_ctl_t   ctl;
    rom_phase_e phase_q;
    logic       resume_q;
    logic       id_last;
    logic       id_match;
    logic       at_cmd;

    assign at_cmd = (phase_q == PH_CMD);

    rom_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .search_ok  (search_ok),
        .resume_q   (resume_q),
        .id_last    (id_last),
        .id_match   (id_match),
        .ctl        (ctl),
        .phase_q    (phase_q),
        .fn_enter_q (fn_enter)
    );

    rom_id_cmp #(
        .ID_W   (ID_W),
        .DEV_ID (DEV_ID)
    ) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.id_clear),
        .step     (ctl.id_step),
        .data     (byte_data),
        .id_last  (id_last),
        .id_match (id_match)
    );

    rom_flag_regs u_flags (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .reset_long (reset_long),
        .ctl        (ctl),
        .resume_q   (resume_q),
        .od_q       (od_mode)
    );

endmodule

// File: rtl/sw_rom_layer_chk.sv
module sw_rom_layer_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_reset,
    input logic       reset_long,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       od_mode,
    input logic       fn_enter,
    input logic       at_cmd,
    input logic       resume_q
);

    p_long_reset_clears_od_r2: assert property (@(posedge clk) disable iff (rst)
        bus_reset && reset_long |=> !od_mode);

    p_short_reset_keeps_od_r2: assert property (@(posedge clk) disable iff (rst)
        bus_reset && !reset_long |=> od_mode == $past(od_mode));

    p_od_skip_enters_r6: assert property (@(posedge clk) disable iff (rst)
        at_cmd && byte_vld && !bus_reset && byte_data == 8'h3C
        |=> od_mode && fn_enter && !resume_q);

    p_resume_gated_r9: assert property (@(posedge clk) disable iff (rst)
        at_cmd && byte_vld && !bus_reset && byte_data == 8'hA5
        |=> fn_enter == $past(resume_q));

    p_od_rise_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(od_mode) |-> $past(at_cmd && byte_vld && !bus_reset &&
                                 (byte_data == 8'h3C || byte_data == 8'h69)));

    p_enter_single_r12: assert property (@(posedge clk) disable iff (rst)
        fn_enter |=> !fn_enter);

endmodule

bind sw_rom_layer sw_rom_layer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_reset  (bus_reset),
    .reset_long (reset_long),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .od_mode    (od_mode),
    .fn_enter   (fn_enter),
    .at_cmd     (at_cmd),
    .resume_q   (resume_q)
);

// File: tb/sim_sw_rom_layer.sv
`timescale 1ns/1ps
module sim_sw_rom_layer;

    localparam logic [63:0] ID = 64'h3D5A_9C17_E402_B86F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_reset = 1'b0;
    logic       reset_long = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       search_ok = 1'b0;
    logic       od_mode;
    logic       fn_enter;

    int checks = 0;
    int failures = 0;

    // reference model state: 0 silent, 1 command, 2 identity, 3 search, 4 function
    int       m_st = 0;
    bit       m_od = 0, m_rs = 0, m_prev = 0, m_isod = 0, m_en = 0;
    bit [7:0] idq[$];

    always #4 clk = ~clk;

    sw_rom_layer #(.ID_W(64), .DEV_ID(ID)) u0 (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .reset_long(reset_long),
        .byte_vld(byte_vld), .byte_data(byte_data), .search_ok(search_ok),
        .od_mode(od_mode), .fn_enter(fn_enter)
    );

    function automatic bit [7:0] idb(input int i);
        return ID[i*8 +: 8];
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (fn_enter !== m_en) begin
            failures++;
            $display("FAIL %s fn_enter actual=%b expected=%b t=%0t", tag, fn_enter, m_en, $time);
        end
        checks++;
        if (od_mode !== m_od) begin
            failures++;
            $display("FAIL %s od_mode actual=%b expected=%b t=%0t", tag, od_mode, m_od, $time);
        end
    endtask

    task automatic model_step(input bit rv, rl, bv, input bit [7:0] b, input bit so);
        bit ok;
        m_en = 0;
        if (rv) begin
            m_st = 1;
            if (rl) m_od = 0;
            idq.delete();
        end else begin
            case (m_st)
                1: if (bv) begin
                    if (b == 8'h55) begin m_isod = 0; idq.delete(); m_st = 2; end
                    else if (b == 8'h69) begin m_prev = m_od; m_od = 1; m_isod = 1; idq.delete(); m_st = 2; end
                    else if (b == 8'hCC) begin m_rs = 0; m_en = 1; m_st = 4; end
                    else if (b == 8'h3C) begin m_rs = 0; m_od = 1; m_en = 1; m_st = 4; end
                    else if (b == 8'hA5) begin
                        if (m_rs) begin m_en = 1; m_st = 4; end else m_st = 0;
                    end
                    else if (b == 8'hF0) begin m_rs = 0; m_st = 3; end
                    else m_st = 0;
                end
                2: if (bv) begin
                    idq.push_back(b);
                    if (idq.size() == 8) begin
                        ok = 1;
                        foreach (idq[i]) if (idq[i] != idb(i)) ok = 0;
                        if (ok) begin m_rs = 1; m_en = 1; m_st = 4; end
                        else begin m_rs = 0; if (m_isod) m_od = m_prev; m_st = 0; end
                    end
                end
                3: if (so) begin m_rs = 1; m_en = 1; m_st = 4; end
                default: ;
            endcase
        end
    endtask

    // one clock: drive at falling edge, model one edge, compare at next falling edge
    task automatic cyc(input bit rv, rl, bv, input bit [7:0] b, input bit so, input string tag);
        bus_reset = rv; reset_long = rl; byte_vld = bv; byte_data = b; search_ok = so;
        model_step(rv, rl, bv, b, so);
        @(posedge clk);
        @(negedge clk);
        bus_reset = 0; reset_long = 0; byte_vld = 0; byte_data = 8'h00; search_ok = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 8'h00, 0, tag);
    endtask
    task automatic breset(input bit lng, input string tag);
        cyc(1, lng, 0, 8'h00, 0, tag);
    endtask
    task automatic sbyte(input bit [7:0] b, input string tag);
        cyc(0, 0, 1, b, 0, tag);
    endtask
    task automatic send_id(input int bad_idx, input bit gaps, input string tag);
        for (int i = 0; i < 8; i++) begin
            sbyte((i == bad_idx) ? (idb(i) ^ 8'h10) : idb(i), tag);
            if (gaps) idle(tag);
        end
        idle(tag);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R1 reset state");
        // R1: commands before the first bus reset are ignored
        sbyte(8'hCC, "R1 no bus reset yet"); idle("R1");
        // R5 skip
        breset(0, "R2"); sbyte(8'hCC, "R5 skip"); idle("R5");
        // R11: bytes in function stage ignored
        sbyte(8'hA5, "R11 func stage"); sbyte(8'h3C, "R11 func stage"); idle("R11");
        // R3 match with gaps
        breset(0, "R2"); sbyte(8'h55, "R3"); send_id(-1, 1, "R3 match gaps");
        // R9 resume with flag set, twice
        breset(0, "R2"); sbyte(8'hA5, "R9 resume set"); idle("R9");
        breset(0, "R2"); sbyte(8'hA5, "R9 resume again"); idle("R9");
        // R4 mismatch in last byte, then later bytes ignored
        breset(0, "R2"); sbyte(8'h55, "R4"); send_id(7, 0, "R4 last byte wrong");
        sbyte(8'hCC, "R4 silent"); idle("R4");
        breset(0, "R2"); sbyte(8'hA5, "R9 resume clear"); sbyte(8'hCC, "R9 silent"); idle("R9");
        // R4 mismatch in first byte
        breset(0, "R2"); sbyte(8'h55, "R4"); send_id(0, 1, "R4 first byte wrong");
        // R10 search
        breset(0, "R2"); cyc(0, 0, 0, 8'h00, 1, "R10 strobe in command phase");
        sbyte(8'hF0, "R10 search"); idle("R10"); cyc(0, 0, 0, 8'h00, 1, "R10 search won"); idle("R10");
        breset(0, "R2"); sbyte(8'hA5, "R9 after search"); idle("R9");
        breset(0, "R2"); sbyte(8'hF0, "R10 search lost");
        breset(0, "R2 abandon search"); sbyte(8'hA5, "R10 resume cleared by search"); idle("R10");
        // R6 overdrive skip, short reset keeps speed
        breset(0, "R2"); sbyte(8'h3C, "R6 od skip"); idle("R6");
        breset(0, "R2 short keeps od"); sbyte(8'hA5, "R6 resume cleared"); idle("R6");
        // R2 reset wins over a byte in the same cycle, long reset drops speed
        cyc(1, 1, 1, 8'hCC, 0, "R2 long reset with byte"); idle("R2");
        // R7 overdrive match
        sbyte(8'h69, "R7 od match"); send_id(-1, 0, "R7 match");
        breset(0, "R2"); sbyte(8'hA5, "R7 resume after od match"); idle("R7");
        // R8 failed od match from standard speed
        breset(1, "R2 long"); sbyte(8'h69, "R8"); send_id(3, 1, "R8 from standard");
        // R8 failed od match from fast speed
        breset(0, "R2"); sbyte(8'h3C, "R6"); breset(0, "R2");
        sbyte(8'h69, "R8"); send_id(5, 0, "R8 from fast");
        breset(0, "R2"); sbyte(8'hA5, "R8 resume cleared"); idle("R8");
        // R11 unknown command
        breset(1, "R2"); sbyte(8'h12, "R11 unknown"); sbyte(8'hCC, "R11 silent"); idle("R11");
        // R12 back-to-back opportunities never give two-cycle pulses
        breset(0, "R2"); sbyte(8'hCC, "R12"); sbyte(8'hCC, "R12 no second pulse"); idle("R12");
        repeat (3) idle("R12");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule